// File: doc/BRIEF.md
# Instruction Parcel Buffer Set

This block is a tiny, fully associative instruction store that sits in front of an issue stage and hands it 16-bit instruction parcels. It has four buffers. Each buffer holds one aligned block of 64 consecutive parcels, and each has a base-address register holding the block's upper address bits. A request carries a 22-bit parcel address. The upper 16 bits are compared against every valid buffer at once, and the lower 6 bits pick the parcel inside the matching buffer.

When no buffer matches, the block stalls the requester and refills one buffer from a simple word-wide memory read port. It then delivers the parcel that was asked for. The buffer to overwrite is chosen by a 2-bit counter that advances on every miss, so blocks leave in the order they came in. An invalidate-all input drops every buffer at once, for example after code has been rewritten.

Top module: `parcel_buffer_set`

## Requirements
- R1: After reset, parcel_valid, stall and mem_req are low and every buffer is invalid, so the first request always misses.
- R2: When the block is not stalled and a request arrives whose bits 21:6 equal the tag of a valid buffer, parcel_valid is high in the next cycle and parcel_data is the parcel at offset bits 5:0 of that block. Such hits may be issued every cycle.
- R3: On a miss, stall is high from the cycle after the request until the refill ends, and parcel_valid stays low throughout. One cycle after the last memory word is accepted, stall drops and parcel_valid rises in the same cycle, carrying the requested parcel.
- R4: A refill reads 16 words. mem_req stays high with mem_addr = {block tag, 4-bit word index}, starting at index 0. The index advances by one only in a cycle in which mem_ack is high, and mem_addr is held otherwise.
- R5: In each 64-bit memory word w, bits 63:48 land at block offset 4w, bits 47:32 at 4w+1, bits 31:16 at 4w+2 and bits 15:0 at 4w+3.
- R6: A 2-bit counter, zero after reset, names the buffer each miss refills, and the counter then increments. The fifth distinct block missed therefore evicts the first, and so on in arrival order.
- R7: When flush_all is high at a clock edge, every buffer becomes invalid, so the next request to any block held before the flush misses. The replacement counter keeps its value.
- R8: Requests presented while stall is high are ignored. The parcel delivered at the end of a refill is the one whose address was captured at the miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Invalidate every buffer at this edge |
| req_valid | input | 1 | Parcel request strobe |
| req_addr | input | 22 | Parcel address: tag in 21:6, offset in 5:0 |
| parcel_valid | output | 1 | parcel_data holds a delivered parcel |
| parcel_data | output | 16 | Delivered instruction parcel |
| stall | output | 1 | Refill in progress; requests are ignored |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 20 | 64-bit word address of the read |
| mem_ack | input | 1 | Memory returns mem_rdata for mem_addr this cycle |
| mem_rdata | input | 64 | Read data word |

## Verification
The bench starts with single requests to the edges of a block (offsets 0 and 63) and to its middle, and then sends a burst of hits on consecutive cycles. Together these separate correct offset indexing and a one-cycle hit latency from off-by-one or pipeline slips. It then misses on five distinct blocks and revisits them, which tells first-in first-out eviction apart from any other victim choice. Memory acknowledgements arrive with a mix of zero and one-to-two idle cycles between them, which exposes a refill that advances without an acknowledgement. Finally, junk requests are sent during a refill, and a request follows a flush, to show that input is ignored while stalled and that the flush drops every buffer. Every parcel value is a function of its address, so a wrong word lane or buffer shows up as a data mismatch.

// File: rtl/parcel_buffer_set.sv
module parcel_buffer_set #(
  parameter int TAG_W = 16,
  parameter int OFF_W = 6,
  parameter int NBUF  = 4,
  parameter int PW    = 16,
  parameter int MW    = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush_all,
  input  logic                     req_valid,
  input  logic [TAG_W+OFF_W-1:0]   req_addr,
  output logic                     parcel_valid,
  output logic [PW-1:0]            parcel_data,
  output logic                     stall,
  output logic                     mem_req,
  output logic [TAG_W+OFF_W-$clog2(MW/PW)-1:0] mem_addr,
  input  logic                     mem_ack,
  input  logic [MW-1:0]            mem_rdata
);
  localparam int AW     = TAG_W + OFF_W;
  localparam int DEPTH  = 1 << OFF_W;
  localparam int PPW    = MW / PW;
  localparam int WSH    = $clog2(PPW);
  localparam int WCNT_W = OFF_W - WSH;
  localparam int VW     = $clog2(NBUF);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_RESP} state_t;

  state_t             state;
  logic [PW-1:0]      store [NBUF*DEPTH];
  logic [TAG_W-1:0]   tags  [NBUF];
  logic [NBUF-1:0]    valid;
  logic [VW-1:0]      ctr, victim;
  logic [AW-1:0]      pend;
  logic [WCNT_W-1:0]  wcnt;
  logic               hit;
  logic [VW-1:0]      hidx;
  logic [VW+OFF_W-1:0] rd_ptr;
  logic               last_word;

  wire [TAG_W-1:0] req_tag = req_addr[AW-1:OFF_W];

  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = NBUF - 1; i >= 0; i--)
      if (valid[i] && tags[i] == req_tag) begin
        hit  = 1'b1;
        hidx = VW'(i);
      end
  end

  assign rd_ptr    = (state == S_RESP) ? {victim, pend[OFF_W-1:0]} : {hidx, req_addr[OFF_W-1:0]};
  assign last_word = (state == S_FILL) && mem_ack && (wcnt == {WCNT_W{1'b1}});
  assign stall     = (state != S_IDLE);
  assign mem_req   = (state == S_FILL);
  assign mem_addr  = {pend[AW-1:OFF_W], wcnt};

  always_ff @(posedge clk)
    if (state == S_FILL && mem_ack)
      for (int k = 0; k < PPW; k++)
        store[{victim, wcnt, k[WSH-1:0]}] <= mem_rdata[MW-1-k*PW -: PW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      valid        <= '0;
      ctr          <= '0;
      victim       <= '0;
      pend         <= '0;
      wcnt         <= '0;
      parcel_valid <= 1'b0;
      parcel_data  <= '0;
      for (int i = 0; i < NBUF; i++) tags[i] <= '0;
    end else begin
      parcel_valid <= 1'b0;
      case (state)
        S_IDLE:
          if (req_valid) begin
            if (hit) begin
              parcel_valid <= 1'b1;
              parcel_data  <= store[rd_ptr];
            end else begin
              victim <= ctr;
              ctr    <= ctr + 1'b1;
              pend   <= req_addr;
              wcnt   <= '0;
              state  <= S_FILL;
            end
          end
        S_FILL:
          if (mem_ack) begin
            wcnt <= wcnt + 1'b1;
            if (last_word) state <= S_RESP;
          end
        S_RESP: begin
          parcel_valid <= 1'b1;
          parcel_data  <= store[rd_ptr];
          state        <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (flush_all) valid <= '0;
      if (last_word) begin
        valid[victim] <= 1'b1;
        tags[victim]  <= pend[AW-1:OFF_W];
      end
    end
  end
endmodule

// File: rtl/parcel_buffer_set_chk.sv
module parcel_buffer_set_chk #(
  parameter int TAG_W = 16,
  parameter int OFF_W = 6,
  parameter int PW    = 16,
  parameter int MW    = 64
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic parcel_valid,
  input logic stall,
  input logic mem_req,
  input logic mem_ack,
  input logic [TAG_W+OFF_W-$clog2(MW/PW)-1:0] mem_addr
);
  localparam int WC = OFF_W - $clog2(MW / PW);

  a_r3_no_parcel_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !parcel_valid);

  a_r3_release_delivers: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> parcel_valid);

  a_r2_idle_request_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !stall) |=> (parcel_valid || stall));

  a_r4_req_only_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> stall);

  a_r4_hold_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r4_step_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && (mem_addr[WC-1:0] != {WC{1'b1}}))
      |=> (mem_req && mem_addr == $past(mem_addr) + 1'b1));

  a_r4_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && (mem_addr[WC-1:0] == {WC{1'b1}})) |=> (!mem_req && stall));
endmodule

bind parcel_buffer_set parcel_buffer_set_chk #(
  .TAG_W(TAG_W), .OFF_W(OFF_W), .PW(PW), .MW(MW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .parcel_valid(parcel_valid),
  .stall(stall), .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/test_parcel_buffer_set.sv
module test_parcel_buffer_set;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_all = 1'b0;
  logic        req_valid = 1'b0;
  logic [21:0] req_addr = '0;
  logic        parcel_valid;
  logic [15:0] parcel_data;
  logic        stall;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #10 clk = ~clk;

  parcel_buffer_set i_parcel_buffer_set (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .req_valid(req_valid),
    .req_addr(req_addr), .parcel_valid(parcel_valid), .parcel_data(parcel_data),
    .stall(stall), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // scenario-driven inputs
  bit        s_req = 0, s_flush = 0;
  bit [21:0] s_addr = '0;

  // reference model
  int        m_mode = 0;           // 0 idle, 1 refill, 2 respond
  int        m_tag [4];
  bit        m_val [4];
  int        m_ctr = 0, m_victim = 0, m_cnt = 0, m_wait = 0;
  bit [21:0] m_pend = '0;
  bit        e_pv = 0;
  bit [15:0] e_pd = '0;
  string     e_tag = "R2";
  bit [15:0] last_pd = '0;

  function automatic bit [15:0] pval(input bit [21:0] a);
    bit [15:0] p;
    p = a[15:0] * 16'd40503;
    return p ^ {10'd0, a[21:16]};
  endfunction

  function automatic bit [63:0] word_of(input bit [19:0] wa);
    bit [63:0] w;
    for (int k = 0; k < 4; k++) w[63-16*k -: 16] = pval({wa, k[1:0]});
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    bit ack, n_pv, set_v, found;
    @(negedge clk);
    check(parcel_valid == e_pv, "R2", "parcel_valid", parcel_valid, e_pv);
    if (e_pv) begin
      check(parcel_data == e_pd, e_tag, "parcel_data", parcel_data, e_pd);
      last_pd = parcel_data;
    end
    check(stall == (m_mode != 0), "R3", "stall", stall, m_mode != 0);
    check(mem_req == (m_mode == 1), "R4", "mem_req", mem_req, m_mode == 1);
    if (m_mode == 1)
      check(mem_addr == {m_pend[21:6], m_cnt[3:0]}, "R4", "mem_addr", mem_addr,
            {m_pend[21:6], m_cnt[3:0]});
    ack = (m_mode == 1) && (m_wait == 0);
    mem_ack   = ack;
    mem_rdata = ack ? word_of({m_pend[21:6], m_cnt[3:0]}) : 64'h0;
    req_valid = s_req;
    req_addr  = s_addr;
    flush_all = s_flush;
    n_pv = 0; set_v = 0;
    if (m_mode == 0) begin
      if (s_req) begin
        found = 0;
        for (int i = 0; i < 4; i++)
          if (!found && m_val[i] && m_tag[i] == int'(s_addr[21:6])) found = 1;
        if (found) begin
          n_pv = 1; e_pd = pval(s_addr); e_tag = "R2";
        end else begin
          m_victim = m_ctr; m_ctr = (m_ctr + 1) % 4;
          m_pend = s_addr; m_cnt = 0; m_mode = 1;
        end
      end
    end else if (m_mode == 1) begin
      if (ack) begin
        m_cnt++;
        m_wait = m_cnt % 3;
        if (m_cnt == 16) begin set_v = 1; m_mode = 2; end
      end else m_wait--;
    end else begin
      n_pv = 1; e_pd = pval(m_pend); e_tag = "R5"; m_mode = 0;
    end
    if (s_flush) for (int i = 0; i < 4; i++) m_val[i] = 0;
    if (set_v) begin m_val[m_victim] = 1; m_tag[m_victim] = int'(m_pend[21:6]); end
    e_pv = n_pv;
  endtask

  task automatic access(input bit [21:0] a, input bit junk, output bit missed);
    s_req = 1; s_addr = a; step();
    missed = (m_mode != 0);
    s_req = junk; s_addr = a ^ 22'h3F_FFC0;
    while (!e_pv) step();
    s_req = 0;
    step();
  endtask

  function automatic bit [21:0] mk(input bit [15:0] t, input int off);
    return {t, off[5:0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    bit m;
    bit [15:0] tA = 16'h1000, tB = 16'h2111, tC = 16'h3222, tD = 16'h4333,
               tE = 16'h5444, tF = 16'h6555;
    for (int i = 0; i < 4; i++) begin m_tag[i] = 0; m_val[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();                                           // R1 reset outputs
    check(!parcel_valid && !stall && !mem_req, "R1", "reset outputs",
          {parcel_valid, stall, mem_req}, 0);
    access(mk(tA, 5), 0, m);  check(m, "R1", "first request misses", m, 1);
    access(mk(tA, 0), 0, m);  check(!m, "R2", "hit offset 0", m, 0);
    access(mk(tA, 63), 0, m); check(!m, "R2", "hit offset 63", m, 0);
    access(mk(tB, 17), 0, m); check(m, "R6", "B misses", m, 1);
    access(mk(tC, 40), 0, m); check(m, "R6", "C misses", m, 1);
    access(mk(tD, 2), 0, m);  check(m, "R6", "D misses", m, 1);
    access(mk(tB, 62), 0, m); check(!m, "R6", "B resident", m, 0);
    access(mk(tA, 33), 0, m); check(!m, "R6", "A resident", m, 0);
    for (int i = 0; i < 8; i++) begin               // R2 back-to-back hits
      s_req = 1; s_addr = mk((i % 2) ? tC : tD, i * 7 + 1); step();
    end
    s_req = 0; step(); step();
    access(mk(tE, 9), 0, m);  check(m, "R6", "E misses", m, 1);
    access(mk(tA, 9), 0, m);  check(m, "R6", "A evicted first", m, 1);
    access(mk(tD, 30), 0, m); check(!m, "R6", "D still resident", m, 0);
    access(mk(tE, 50), 0, m); check(!m, "R6", "E resident", m, 0);
    access(mk(tF, 21), 1, m); check(m, "R8", "F misses", m, 1);
    check(last_pd == pval(mk(tF, 21)), "R8", "parcel of captured address",
          last_pd, pval(mk(tF, 21)));
    s_flush = 1; step(); s_flush = 0; step();
    access(mk(tD, 30), 0, m); check(m, "R7", "D misses after flush", m, 1);
    access(mk(tD, 31), 0, m); check(!m, "R7", "D refilled", m, 0);
    access(mk(tF, 21), 0, m); check(m, "R7", "F misses after flush", m, 1);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end
endmodule